// File: doc/BRIEF.md
# Phase-Continuous Two-Page Waveform Synthesizer Channel

One channel of a direct digital synthesizer. A phase register is advanced by a programmable frequency step on every sample clock, wrapping modulo 2^PHASE_W. The most significant ADDR_W phase bits index one period of a stored waveform, and an active-page bit selects which of two equal table pages is played. The output frequency is step * fclk / 2^PHASE_W, so a step of 1 gives the finest frequency resolution.

A controller loads a new waveform into the idle page through a write port while the other page plays. It then asks for a page swap. The swap flips the page bit and leaves the phase register alone, so the new waveform starts at the same point in the period and no phase jump appears. The channel drives two 12-bit offset-binary codes, with 2048 as zero: a sample code for the first converter stage and a separately loaded amplitude/polarity code for the second scaling stage. The full-size setting is PHASE_W=32 and ADDR_W=12. The default ADDR_W is 8 so that the table model stays small.

Top module: `dds_pingpong_channel`

## Requirements
- R1: While `run` is high and `clr` is low, each rising edge adds the current step word to the phase register, modulo 2^PHASE_W. While `run` is low the phase holds.
- R2: At each rising edge with `run` high, the table word at address {active page, phase[PHASE_W-1 -: ADDR_W]} is read. Its upper CODE_W bits appear on `sample_code` after that edge, one cycle after the address.
- R3: `sample_valid` is high for exactly the cycles that follow an edge with `run` high. After an edge with `run` low, `sample_valid` is low and `sample_code` keeps its previous value.
- R4: `clr` high at an edge sets the phase to zero, whatever the state of `run`. A read made at that same edge still uses the address from before the clear.
- R5: `swap_req` high at an edge toggles `active_page` at that edge (0 = page A, 1 = page B). Reads from the next edge onward use the new page. The phase is not changed by a swap.
- R6: `wr_en` high at an edge writes `wr_data` to entry `wr_addr` of page `wr_page`, whichever page is active. A read of the same entry at the same edge returns the old word.
- R7: `wr_hit_active` is high for the one cycle after a write whose `wr_page` equals `active_page` as it stood before that edge. It is low otherwise.
- R8: `step_we` high at an edge loads `step_in` into the step register. The new step is first added at the following edge.
- R9: `gain_we` high at an edge loads `gain_in` onto `gain_code`. Otherwise `gain_code` holds.
- R10: While `rst_n` is low, the phase, step and page bit are zero, `sample_code` and `gain_code` are 2048, and `sample_valid` and `wr_hit_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables accumulation and table reads |
| clr | input | 1 | Synchronous phase clear |
| step_we | input | 1 | Load strobe for the step word |
| step_in | input | PHASE_W | Frequency step word |
| swap_req | input | 1 | Toggle the active page |
| wr_en | input | 1 | Table write strobe |
| wr_page | input | 1 | Page selected by the write |
| wr_addr | input | ADDR_W | Entry within the page |
| wr_data | input | WORD_W | Word to store |
| gain_we | input | 1 | Load strobe for the amplitude code |
| gain_in | input | CODE_W | Amplitude/polarity code, offset binary |
| sample_code | output | CODE_W | First-stage sample code, offset binary |
| sample_valid | output | 1 | Marks a new sample |
| gain_code | output | CODE_W | Second-stage amplitude/polarity code |
| active_page | output | 1 | Page currently played |
| wr_hit_active | output | 1 | The last write targeted the playing page |

## Verification
A wrong phase value shows up on `sample_code` one cycle after the faulty edge, as a table entry from the wrong position in the period. Distinct table contents therefore turn any accumulator or step error into a code mismatch almost at once. A page bit that is wrong, or that flips at the wrong edge, shows up as a word from the other page on the next valid sample and as a wrong `active_page`. A swap that disturbed the phase would break the address sequence at the swap point. Every cycle the bench compares all outputs with a behavioural model, so the first cycle that diverges is reported.

// File: rtl/dds_pkg.sv
package dds_pkg;
   typedef enum logic {PAGE_A = 1'b0, PAGE_B = 1'b1} page_e;

   function automatic logic [31:0] mid_code(input int unsigned w);
      return 32'd1 << (w - 1);
   endfunction
endpackage

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
   parameter int unsigned PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               clr,
   input  logic               step_we,
   input  logic [PHASE_W-1:0] step_in,
   output logic [PHASE_W-1:0] phase,
   output logic [PHASE_W-1:0] step
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         step  <= '0;
      end else begin
         if (clr)          phase <= '0;
         else if (run)     phase <= phase + step;
         if (step_we)      step  <= step_in;
      end
   end
endmodule

// File: rtl/dds_page_ctl.sv
module dds_page_ctl
   import dds_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic swap_req,
   input  logic wr_en,
   input  logic wr_page,
   output logic active_page,
   output logic wr_hit
);
   page_e page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= PAGE_A;
         wr_hit <= 1'b0;
      end else begin
         if (swap_req) page_q <= (page_q == PAGE_A) ? PAGE_B : PAGE_A;
         wr_hit <= wr_en && (wr_page == logic'(page_q));
      end
   end

   assign active_page = logic'(page_q);
endmodule

// File: rtl/dds_wave_ram.sv
module dds_wave_ram
   import dds_pkg::*;
#(
   parameter int unsigned AW            = 9,
   parameter int unsigned WORD_W        = 16,
   parameter int unsigned CODE_W        = 12,
   parameter bit          CODE_FROM_MSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic [CODE_W-1:0] code,
   output logic              valid
);
   localparam int unsigned DEPTH = 1 << AW;
   localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] rd_word;
   logic [CODE_W-1:0] rd_code;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_word = mem[rd_addr];

   generate
      if (CODE_FROM_MSB) begin : g_msb
         assign rd_code = rd_word[WORD_W-1 -: CODE_W];
      end else begin : g_lsb
         assign rd_code = rd_word[CODE_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code  <= MID;
         valid <= 1'b0;
      end else begin
         valid <= rd_en;
         if (rd_en) code <= rd_code;
      end
   end
endmodule

// File: rtl/dds_pingpong_channel.sv
module dds_pingpong_channel
   import dds_pkg::*;
#(
   parameter int unsigned PHASE_W       = 32,
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned WORD_W        = 16,
   parameter int unsigned CODE_W        = 12,
   parameter bit          CODE_FROM_MSB = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               clr,
   input  logic               step_we,
   input  logic [PHASE_W-1:0] step_in,
   input  logic               swap_req,
   input  logic               wr_en,
   input  logic               wr_page,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic               gain_we,
   input  logic [CODE_W-1:0]  gain_in,
   output logic [CODE_W-1:0]  sample_code,
   output logic               sample_valid,
   output logic [CODE_W-1:0]  gain_code,
   output logic               active_page,
   output logic               wr_hit_active
);
   localparam int unsigned TBL_AW = ADDR_W + 1;
   localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

   generate
      if (ADDR_W > PHASE_W) begin : g_bad_addr
         $error("ADDR_W must not exceed PHASE_W");
      end
      if (CODE_W > WORD_W) begin : g_bad_code
         $error("CODE_W must not exceed WORD_W");
      end
      if (CODE_W < 2) begin : g_bad_cw
         $error("CODE_W must be at least 2");
      end
   endgenerate

   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] step_q;
   logic [TBL_AW-1:0]  rd_addr;
   logic [TBL_AW-1:0]  wr_full;

   dds_phase_accum #(.PHASE_W(PHASE_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(clr),
      .step_we(step_we), .step_in(step_in),
      .phase(phase_q), .step(step_q)
   );

   dds_page_ctl u_page (
      .clk(clk), .rst_n(rst_n), .swap_req(swap_req),
      .wr_en(wr_en), .wr_page(wr_page),
      .active_page(active_page), .wr_hit(wr_hit_active)
   );

   assign rd_addr = {active_page, phase_q[PHASE_W-1 -: ADDR_W]};
   assign wr_full = {wr_page, wr_addr};

   dds_wave_ram #(
      .AW(TBL_AW), .WORD_W(WORD_W), .CODE_W(CODE_W), .CODE_FROM_MSB(CODE_FROM_MSB)
   ) u_ram (
      .clk(clk), .rst_n(rst_n), .rd_en(run), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_full), .wr_data(wr_data),
      .code(sample_code), .valid(sample_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gain_code <= MID;
      else if (gain_we) gain_code <= gain_in;
   end
endmodule

// File: rtl/dds_channel_chk.sv
module dds_channel_chk #(
   parameter int unsigned PHASE_W = 32,
   parameter int unsigned CODE_W  = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic               clr,
   input logic               swap_req,
   input logic               wr_en,
   input logic               wr_page,
   input logic               gain_we,
   input logic [PHASE_W-1:0] phase_q,
   input logic [PHASE_W-1:0] step_q,
   input logic [CODE_W-1:0]  sample_code,
   input logic               sample_valid,
   input logic [CODE_W-1:0]  gain_code,
   input logic               active_page,
   input logic               wr_hit_active
);
   AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr) |=> (phase_q == $past(phase_q) + $past(step_q))); // R1
   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(phase_q)); // R1
   AST_VALID_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> sample_valid); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!sample_valid && $stable(sample_code))); // R3
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (phase_q == '0)); // R4
   AST_SWAP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      swap_req |=> (active_page != $past(active_page))); // R5
   AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !swap_req |=> $stable(active_page)); // R5
   AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_page == active_page)) |=> wr_hit_active); // R7
   AST_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !wr_hit_active); // R7
   AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !gain_we |=> $stable(gain_code)); // R9
endmodule

bind dds_pingpong_channel dds_channel_chk #(.PHASE_W(PHASE_W), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .swap_req(swap_req),
   .wr_en(wr_en), .wr_page(wr_page), .gain_we(gain_we),
   .phase_q(phase_q), .step_q(step_q), .sample_code(sample_code),
   .sample_valid(sample_valid), .gain_code(gain_code),
   .active_page(active_page), .wr_hit_active(wr_hit_active)
);

// File: tb/dds_pingpong_channel_test.sv
`timescale 1ns/1ps
module dds_pingpong_channel_test;
   localparam int PW = 32;
   localparam int AW = 8;
   localparam int WW = 16;
   localparam int CW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run = 0, clr = 0, step_we = 0, swap_req = 0, wr_en = 0, wr_page = 0, gain_we = 0;
   logic [PW-1:0] step_in = '0;
   logic [AW-1:0] wr_addr = '0;
   logic [WW-1:0] wr_data = '0;
   logic [CW-1:0] gain_in = '0;
   logic [CW-1:0] sample_code, gain_code;
   logic sample_valid, active_page, wr_hit_active;

   int checks = 0;
   int failures = 0;
   string tag = "R10";

   always #5 clk = ~clk;

   dds_pingpong_channel uut (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .step_we(step_we), .step_in(step_in),
      .swap_req(swap_req), .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr),
      .wr_data(wr_data), .gain_we(gain_we), .gain_in(gain_in),
      .sample_code(sample_code), .sample_valid(sample_valid), .gain_code(gain_code),
      .active_page(active_page), .wr_hit_active(wr_hit_active)
   );

   // behavioural reference model
   logic [WW-1:0] m_mem [2*(1<<AW)];
   logic [PW-1:0] m_ph, m_step;
   logic m_page, m_valid, m_hit;
   logic [CW-1:0] m_samp, m_gain;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = '0; m_step = '0; m_page = 0; m_valid = 0; m_hit = 0;
         m_samp = 12'd2048; m_gain = 12'd2048;
      end else begin
         int idx;
         idx = int'(m_page) * (1 << AW) + int'(m_ph >> (PW - AW));
         m_valid = run;
         if (run) m_samp = m_mem[idx][WW-1 -: CW];
         m_hit = wr_en && (wr_page == m_page);
         if (wr_en) m_mem[int'(wr_page) * (1 << AW) + int'(wr_addr)] = wr_data;
         if (swap_req) m_page = ~m_page;
         if (clr) m_ph = '0;
         else if (run) m_ph = m_ph + m_step;
         if (step_we) m_step = step_in;
         if (gain_we) m_gain = gain_in;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // compare all outputs, then drive the next inputs
   task automatic step_cycle();
      @(negedge clk);
      chk(tag, "sample_code", int'(sample_code), int'(m_samp));
      chk("R3", "sample_valid", int'(sample_valid), int'(m_valid));
      chk("R5", "active_page", int'(active_page), int'(m_page));
      chk("R7", "wr_hit_active", int'(wr_hit_active), int'(m_hit));
      chk("R9", "gain_code", int'(gain_code), int'(m_gain));
   endtask

   function automatic logic [WW-1:0] pat(input int pg, input int a);
      if (pg == 0) return WW'(a * 257 + 3);
      else         return WW'(16'hFFFF - a * 200);
   endfunction

   task automatic fill(input int pg, input int salt);
      for (int a = 0; a < (1 << AW); a++) begin
         wr_en = 1; wr_page = pg[0]; wr_addr = AW'(a); wr_data = pat(pg, a) ^ WW'(salt);
         step_cycle();
      end
      wr_en = 0;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) step_cycle();
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R10: reset values
      repeat (3) @(negedge clk);
      chk("R10", "reset sample_code", int'(sample_code), 2048);
      chk("R10", "reset gain_code", int'(gain_code), 2048);
      chk("R10", "reset valid", int'(sample_valid), 0);
      chk("R10", "reset page", int'(active_page), 0);
      rst_n = 1;
      // R6/R7: fill active page A (flag) and idle page B (no flag)
      tag = "R6"; fill(0, 0); fill(1, 0);
      // R8: load step, R9: load gain
      tag = "R8"; step_we = 1; step_in = 32'h0100_0000; gain_we = 1; gain_in = 12'd3000;
      step_cycle(); step_we = 0; gain_we = 0;
      // R1/R2: run with unit address step
      tag = "R2"; run = 1; cycles(40);
      // R8: step changed while running
      tag = "R8"; step_we = 1; step_in = 32'h0370_1234; step_cycle(); step_we = 0; cycles(60);
      // R3: pause holds output
      tag = "R3"; run = 0; cycles(10); run = 1; cycles(5);
      // R5: swap while running, phase continues
      tag = "R5"; swap_req = 1; step_cycle(); swap_req = 0; cycles(30);
      // R5: swap while stopped
      run = 0; swap_req = 1; step_cycle(); swap_req = 0; run = 1; cycles(20);
      // R4: clear while running, then clear while stopped
      tag = "R4"; clr = 1; step_cycle(); clr = 0; cycles(10);
      run = 0; clr = 1; step_cycle(); clr = 0; run = 1; cycles(10);
      // R1: wrap with large step (effectively descending)
      tag = "R1"; step_we = 1; step_in = 32'hFF00_0001; step_cycle(); step_we = 0; cycles(300);
      // R6: rewrite idle page while playing, then swap onto it
      tag = "R6"; fill(~m_page ? 1 : 0, 16'h0F0F);
      swap_req = 1; step_cycle(); swap_req = 0; cycles(40);
      // R7: write into the playing page while running
      tag = "R7"; fill(m_page ? 1 : 0, 16'h3C3C); cycles(20);
      // R9: gain change with negative sign
      tag = "R9"; gain_we = 1; gain_in = 12'd100; step_cycle(); gain_we = 0; cycles(5);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule